// File: doc/BRIEF.md
# Receive Descriptor Prefetch Scheduler

This block decides, once per clock, which of several receive queues may issue the next descriptor-read request and how many descriptors that request asks for. Each queue presents its prefetch-buffer fill level, the number of descriptors the host has made available in its ring, a priority value, an enable bit and a permission bit for short requests. Global settings supply the thresholds, the burst limits and the arbitration mode.

A granted request appears on the output one cycle after the decision as a single-cycle pulse carrying the queue index and the descriptor count. The scheduler keeps a count of reads in flight and stops granting when that count reaches a programmable limit. A completion pulse returns one credit. The most recently granted queue can hold on to the grant while its buffer is nearly empty, or unconditionally when forced. The block also raises a per-queue almost-full flag from the fill level.

Top module: `desc_pf_sched`

## Requirements
- R1: While reset is held, and for two clock edges after it is released, `req_valid` is 0 and no credit is in use.
- R2: A granted request's count equals the smallest of three values: the host descriptors available, the free buffer space (DEPTH minus level), and `cfg_max_burst`.
- R3: When a queue's level is strictly below `cfg_pref_thr`, its minimum burst is one descriptor.
- R4: When a queue's level is equal to or above `cfg_pref_thr`, its minimum burst is `cfg_min_above`, where a value of 0 counts as 1. A queue whose computed count is below that minimum is not granted.
- R5: If a queue's short-request bit is 1 and its available count is below the minimum burst, it may still be granted. This holds only when the count equals its available count and is nonzero.
- R6: A queue is never granted when it is disabled, when it has zero host descriptors, or when its level is at or above DEPTH.
- R7: With `cfg_force_rr` = 0 and no promotion, the eligible queue with the largest priority value wins. Ties go to the first such queue in ascending circular order that starts just after the last granted queue. After reset that order starts at queue 0.
- R8: With `cfg_force_rr` = 1, priority values are ignored and the first eligible queue in circular order after the last granted queue wins.
- R9: With `cfg_promo_en` = 1, the last granted queue is granted again when it is still eligible and its level is strictly below `cfg_promo_thr`.
- R10: With `cfg_promo_force` = 1, the last granted queue is granted again whenever it is still eligible, whatever its level.
- R11: No grant is made while the reads in flight equal `cfg_max_outst`. Each grant adds one to that count. Each `rd_done` pulse removes one, and the count never goes below zero.
- R12: `afull[i]` is 1 exactly when queue i's level is greater than or equal to `cfg_afull_thr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_lvl | input | NQ*LVL_W | Per-queue buffer fill level, queue i at bits [i*LVL_W +: LVL_W] |
| q_avail | input | NQ*AV_W | Per-queue host descriptors available |
| q_qos | input | NQ*QOS_W | Per-queue priority value, larger wins |
| q_en | input | NQ | Per-queue enable |
| q_allow_short | input | NQ | Per-queue permission for requests below the minimum burst |
| cfg_pref_thr | input | LVL_W | Level threshold that selects the minimum burst |
| cfg_min_above | input | 4 | Minimum burst at or above the threshold |
| cfg_max_burst | input | BW | Largest descriptor count per request |
| cfg_promo_en | input | 1 | Enable promotion of the last granted queue |
| cfg_promo_force | input | 1 | Promote the last granted queue regardless of level |
| cfg_promo_thr | input | LVL_W | Level below which promotion applies |
| cfg_force_rr | input | 1 | 1 = plain round robin, 0 = priority arbitration |
| cfg_max_outst | input | OW | Limit on reads in flight |
| cfg_afull_thr | input | LVL_W | Almost-full level |
| rd_done | input | 1 | One read finished, returns one credit |
| req_valid | output | 1 | Request pulse |
| req_q | output | QW | Granted queue index |
| req_cnt | output | LVL_W | Descriptors requested |
| afull | output | NQ | Per-queue almost-full flag |

## Verification
The assertions take for granted that the configuration inputs stay unchanged while the block is out of reset. They also assume `rd_done` is pulsed only when at least one request has been seen and not yet returned. The credit check compares a count of observed request pulses against the limit, so it depends on both of these. The stimulus changes settings and queue inputs only while reset is held, and it pulses `rd_done` only after the expected requests have appeared and the output has gone idle.

// File: rtl/pf_sched_pkg.sv
package pf_sched_pkg;
  // Where the winning queue came from in one decision cycle.
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_PROMO = 2'd1,
    SRC_ARB   = 2'd2
  } pf_src_e;

  // Floor applied to any minimum burst.
  localparam int unsigned MIN_BURST_FLOOR = 1;
endpackage

// File: rtl/pf_sizer.sv
module pf_sizer #(
  parameter int DEPTH = 16,
  parameter int AV_W  = 8,
  parameter int BW    = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] lvl,
  input  logic [AV_W-1:0]  avail,
  input  logic             en,
  input  logic             allow_short,
  input  logic [LVL_W-1:0] pref_thr,
  input  logic [3:0]       min_above,
  input  logic [BW-1:0]    max_burst,
  output logic             eligible,
  output logic [LVL_W-1:0] cnt
);
  import pf_sched_pkg::*;

  localparam int MW = (AV_W > LVL_W) ? AV_W : LVL_W;
  localparam int WW = ((MW > BW) ? MW : BW) + 1;

  logic [WW-1:0] free_w, av_w, mb_w, c1_w, c_w, minb_w;

  always_comb begin
    free_w = (lvl >= LVL_W'(DEPTH)) ? '0 : (WW'(DEPTH) - WW'(lvl));
    av_w   = WW'(avail);
    mb_w   = WW'(max_burst);
    c1_w   = (av_w < free_w) ? av_w : free_w;
    c_w    = (c1_w < mb_w) ? c1_w : mb_w;
    if ((lvl < pref_thr) || (min_above == 4'd0))
      minb_w = WW'(MIN_BURST_FLOOR);
    else
      minb_w = WW'(min_above);
    eligible = en && (c_w != '0) &&
               ((c_w >= minb_w) ||
                (allow_short && (av_w < minb_w) && (c_w == av_w)));
    cnt = LVL_W'(c_w);
  end
endmodule

// File: rtl/pf_arbiter.sv
module pf_arbiter #(
  parameter int NQ    = 4,
  parameter int QOS_W = 3,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic [NQ-1:0]       elig,
  input  logic [NQ*QOS_W-1:0] qos,
  input  logic [QW-1:0]       last,
  input  logic                force_rr,
  output logic                found,
  output logic [QW-1:0]       pick
);
  logic [QOS_W-1:0] best;
  int idx;

  // Scan in circular order after the last grant; a strictly larger
  // priority displaces the current choice, so ties keep scan order.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    best  = '0;
    idx   = 0;
    for (int k = 1; k <= NQ; k++) begin
      idx = (int'(last) + k) % NQ;
      if (elig[idx] &&
          (!found || (!force_rr && (qos[idx*QOS_W +: QOS_W] > best)))) begin
        found = 1'b1;
        pick  = QW'(idx);
        best  = qos[idx*QOS_W +: QOS_W];
      end
    end
  end
endmodule

// File: rtl/pf_credit.sv
module pf_credit #(
  parameter int OW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          give,
  input  logic [OW-1:0] limit,
  output logic          ok
);
  logic [OW-1:0] used_q, used_d;

  always_comb begin
    used_d = used_q;
    if (take && !(give && (used_q != '0)))
      used_d = used_q + OW'(1);
    else if (!take && give && (used_q != '0))
      used_d = used_q - OW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_d;
  end

  assign ok = (used_q < limit);
endmodule

// File: rtl/desc_pf_sched.sv
module desc_pf_sched #(
  parameter int NQ    = 4,
  parameter int DEPTH = 16,
  parameter int AV_W  = 8,
  parameter int QOS_W = 3,
  parameter int BW    = 4,
  parameter int OW    = 6,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int QW    = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NQ*LVL_W-1:0]  q_lvl,
  input  logic [NQ*AV_W-1:0]   q_avail,
  input  logic [NQ*QOS_W-1:0]  q_qos,
  input  logic [NQ-1:0]        q_en,
  input  logic [NQ-1:0]        q_allow_short,
  input  logic [LVL_W-1:0]     cfg_pref_thr,
  input  logic [3:0]           cfg_min_above,
  input  logic [BW-1:0]        cfg_max_burst,
  input  logic                 cfg_promo_en,
  input  logic                 cfg_promo_force,
  input  logic [LVL_W-1:0]     cfg_promo_thr,
  input  logic                 cfg_force_rr,
  input  logic [OW-1:0]        cfg_max_outst,
  input  logic [LVL_W-1:0]     cfg_afull_thr,
  input  logic                 rd_done,
  output logic                 req_valid,
  output logic [QW-1:0]        req_q,
  output logic [LVL_W-1:0]     req_cnt,
  output logic [NQ-1:0]        afull
);
  import pf_sched_pkg::*;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign arst_n = rst_sync[1];

  // Per-queue sizing and eligibility.
  logic [NQ-1:0]    elig;
  logic [LVL_W-1:0] cnt_a [NQ];

  for (genvar g = 0; g < NQ; g++) begin : g_q
    pf_sizer #(.DEPTH(DEPTH), .AV_W(AV_W), .BW(BW)) u_sizer (
      .lvl         (q_lvl[g*LVL_W +: LVL_W]),
      .avail       (q_avail[g*AV_W +: AV_W]),
      .en          (q_en[g]),
      .allow_short (q_allow_short[g]),
      .pref_thr    (cfg_pref_thr),
      .min_above   (cfg_min_above),
      .max_burst   (cfg_max_burst),
      .eligible    (elig[g]),
      .cnt         (cnt_a[g])
    );
    assign afull[g] = (q_lvl[g*LVL_W +: LVL_W] >= cfg_afull_thr);
  end

  // Last grant state.
  logic [QW-1:0] last_q, last_d;
  logic          has_last_q, has_last_d;

  logic          arb_found;
  logic [QW-1:0] arb_pick;

  pf_arbiter #(.NQ(NQ), .QOS_W(QOS_W)) u_arb (
    .elig     (elig),
    .qos      (q_qos),
    .last     (last_q),
    .force_rr (cfg_force_rr),
    .found    (arb_found),
    .pick     (arb_pick)
  );

  logic credit_ok, grant;

  pf_credit #(.OW(OW)) u_credit (
    .clk   (clk),
    .rst_n (arst_n),
    .take  (grant),
    .give  (rd_done),
    .limit (cfg_max_outst),
    .ok    (credit_ok)
  );

  // Decision.
  logic [LVL_W-1:0] last_lvl;
  logic             promo;
  pf_src_e          src;
  logic [QW-1:0]    win_q;

  logic             valid_d;
  logic [QW-1:0]    q_d;
  logic [LVL_W-1:0] cnt_d;

  always_comb begin
    last_lvl = q_lvl[last_q*LVL_W +: LVL_W];
    promo    = has_last_q && elig[last_q] &&
               (cfg_promo_force || (cfg_promo_en && (last_lvl < cfg_promo_thr)));
    if (promo)          src = SRC_PROMO;
    else if (arb_found) src = SRC_ARB;
    else                src = SRC_NONE;
    win_q = (src == SRC_PROMO) ? last_q : arb_pick;
    grant = credit_ok && (src != SRC_NONE);

    valid_d    = grant;
    q_d        = req_q;
    cnt_d      = req_cnt;
    last_d     = last_q;
    has_last_d = has_last_q;
    if (grant) begin
      q_d        = win_q;
      cnt_d      = cnt_a[win_q];
      last_d     = win_q;
      has_last_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      req_valid  <= 1'b0;
      req_q      <= '0;
      req_cnt    <= '0;
      last_q     <= QW'(NQ - 1);
      has_last_q <= 1'b0;
    end else begin
      req_valid  <= valid_d;
      req_q      <= q_d;
      req_cnt    <= cnt_d;
      last_q     <= last_d;
      has_last_q <= has_last_d;
    end
  end
endmodule

// File: rtl/desc_pf_sched_chk.sv
module desc_pf_sched_chk #(
  parameter int NQ    = 4,
  parameter int DEPTH = 16,
  parameter int AV_W  = 8,
  parameter int BW    = 4,
  parameter int OW    = 6,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int QW    = (NQ > 1) ? $clog2(NQ) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NQ*LVL_W-1:0] q_lvl,
  input logic [NQ*AV_W-1:0]  q_avail,
  input logic [NQ-1:0]       q_en,
  input logic [BW-1:0]       cfg_max_burst,
  input logic [OW-1:0]       cfg_max_outst,
  input logic                rd_done,
  input logic                req_valid,
  input logic [QW-1:0]       req_q,
  input logic [LVL_W-1:0]    req_cnt
);
  logic [NQ*LVL_W-1:0] lvl_prev;
  logic [NQ*AV_W-1:0]  avail_prev;
  logic [NQ-1:0]       en_prev;
  logic [OW:0]         seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev   <= '0;
      avail_prev <= '0;
      en_prev    <= '0;
      seen       <= '0;
    end else begin
      lvl_prev   <= q_lvl;
      avail_prev <= q_avail;
      en_prev    <= q_en;
      if (req_valid && !(rd_done && seen != '0)) seen <= seen + 1'b1;
      else if (!req_valid && rd_done && seen != '0) seen <= seen - 1'b1;
    end
  end

  logic [LVL_W-1:0] lvl_sel;
  logic [AV_W-1:0]  av_sel;
  logic [LVL_W:0]   room_sel;
  assign lvl_sel  = lvl_prev[req_q*LVL_W +: LVL_W];
  assign av_sel   = avail_prev[req_q*AV_W +: AV_W];
  assign room_sel = (lvl_sel >= LVL_W'(DEPTH)) ? '0 : ((LVL_W+1)'(DEPTH) - (LVL_W+1)'(lvl_sel));

  // R11: requests seen in flight never exceed the limit.
  p_credit_limit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seen <= (OW+1)'(cfg_max_outst));

  // R2: count is nonzero and within the burst cap and the host supply.
  p_cnt_bounds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_cnt != '0) && ((LVL_W+BW)'(req_cnt) <= (LVL_W+BW)'(cfg_max_burst))
                  && ((LVL_W+AV_W)'(req_cnt) <= (LVL_W+AV_W)'(av_sel)));

  // R6: the granted queue had room for the burst.
  p_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((LVL_W+1)'(req_cnt) <= room_sel));

  // R6: the granted queue was enabled.
  p_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> en_prev[req_q]);
endmodule

bind desc_pf_sched desc_pf_sched_chk #(
  .NQ(NQ), .DEPTH(DEPTH), .AV_W(AV_W), .BW(BW), .OW(OW)
) u_chk (.*);

// File: tb/tb_desc_pf_sched.sv
module tb_desc_pf_sched;
  localparam int NQ    = 4;
  localparam int DEPTH = 16;
  localparam int AV_W  = 8;
  localparam int QOS_W = 3;
  localparam int BW    = 4;
  localparam int OW    = 6;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int QW    = $clog2(NQ);
  localparam time CLK_P = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic [NQ*LVL_W-1:0] q_lvl;
  logic [NQ*AV_W-1:0]  q_avail;
  logic [NQ*QOS_W-1:0] q_qos;
  logic [NQ-1:0]       q_en, q_allow_short;
  logic [LVL_W-1:0]    cfg_pref_thr, cfg_promo_thr, cfg_afull_thr;
  logic [3:0]          cfg_min_above;
  logic [BW-1:0]       cfg_max_burst;
  logic                cfg_promo_en, cfg_promo_force, cfg_force_rr, rd_done;
  logic [OW-1:0]       cfg_max_outst;
  logic                req_valid;
  logic [QW-1:0]       req_q;
  logic [LVL_W-1:0]    req_cnt;
  logic [NQ-1:0]       afull;

  always #(CLK_P/2) clk = ~clk;

  desc_pf_sched #(.NQ(NQ), .DEPTH(DEPTH), .AV_W(AV_W), .QOS_W(QOS_W),
                  .BW(BW), .OW(OW)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;
  string cur_tag = "R1";
  int exp_q[$];
  int exp_c[$];

  task automatic check(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // Monitor: pops expected grants as requests appear.
  always @(negedge clk) begin
    if (rst_n && req_valid) begin
      if (exp_q.size() == 0) begin
        check(0, cur_tag, "unexpected request on queue", int'(req_q), -1);
      end else begin
        int eq, ec;
        eq = exp_q.pop_front();
        ec = exp_c.pop_front();
        check(int'(req_q) == eq, cur_tag, "granted queue", int'(req_q), eq);
        check(int'(req_cnt) == ec, cur_tag, "request count", int'(req_cnt), ec);
      end
    end
  end

  task automatic set_q(int i, bit en, int lvl, int av, int qos, bit al);
    q_en[i] = en;
    q_allow_short[i] = al;
    q_lvl[i*LVL_W +: LVL_W] = LVL_W'(lvl);
    q_avail[i*AV_W +: AV_W] = AV_W'(av);
    q_qos[i*QOS_W +: QOS_W] = QOS_W'(qos);
  endtask

  task automatic defaults();
    for (int i = 0; i < NQ; i++) set_q(i, 0, 0, 0, 0, 0);
    cfg_pref_thr = 4; cfg_min_above = 4; cfg_max_burst = 8;
    cfg_promo_en = 0; cfg_promo_force = 0; cfg_promo_thr = 0;
    cfg_force_rr = 0; cfg_max_outst = 1; cfg_afull_thr = 12;
    rd_done = 0;
  endtask

  task automatic expect_grant(int q, int c);
    exp_q.push_back(q);
    exp_c.push_back(c);
  endtask

  task automatic begin_case(string tag);
    @(negedge clk);
    rst_n = 0;
    #1;
    cur_tag = tag;
    defaults();
    exp_q.delete();
    exp_c.delete();
  endtask

  task automatic run_case(int n);
    @(negedge clk);
    rst_n = 1;
    repeat (n) @(negedge clk);
    #1;
    check(exp_q.size() == 0, cur_tag, "missing grants", exp_q.size(), 0);
  endtask

  initial begin
    rst_n = 0;
    defaults();
    repeat (3) @(negedge clk);
    check(req_valid == 1'b0, "R1", "req_valid in reset", int'(req_valid), 0);

    // R2 and R7: highest priority wins, count limited by host supply.
    begin_case("R7 priority");
    set_q(0, 1, 0, 20, 1, 0);
    set_q(1, 1, 2, 5, 6, 0);
    expect_grant(1, 5);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    check(req_valid == 1'b0, "R1", "req_valid just after release", int'(req_valid), 0);
    repeat (8) @(negedge clk); #1;
    check(exp_q.size() == 0, cur_tag, "missing grants", exp_q.size(), 0);

    // R7: equal priority rotates from queue 0.
    begin_case("R7 ties");
    for (int i = 0; i < 3; i++) set_q(i, 1, 0, 20, 3, 0);
    cfg_max_outst = 4;
    expect_grant(0, 8); expect_grant(1, 8); expect_grant(2, 8); expect_grant(0, 8);
    run_case(12);

    // R8: forced round robin ignores priority.
    begin_case("R8 force rr");
    set_q(0, 1, 0, 20, 7, 0);
    set_q(1, 1, 0, 20, 0, 0);
    set_q(2, 1, 0, 20, 0, 0);
    cfg_force_rr = 1; cfg_max_outst = 3;
    expect_grant(0, 8); expect_grant(1, 8); expect_grant(2, 8);
    run_case(10);

    // R4 and R3: queue above threshold with too few descriptors skipped.
    begin_case("R4 above threshold");
    set_q(0, 1, 10, 3, 7, 0);
    set_q(1, 1, 0, 2, 0, 0);
    cfg_max_outst = 2;
    expect_grant(1, 2); expect_grant(1, 2);
    run_case(10);

    // R4: level exactly at threshold uses the larger minimum.
    begin_case("R4 at threshold");
    set_q(0, 1, 4, 3, 7, 0);
    set_q(1, 1, 0, 1, 0, 0);
    expect_grant(1, 1);
    run_case(8);

    // R3: below threshold a single descriptor suffices.
    begin_case("R3 below threshold");
    set_q(2, 1, 3, 1, 0, 0);
    expect_grant(2, 1);
    run_case(8);

    // R5: short request allowed.
    begin_case("R5 short allowed");
    set_q(0, 1, 10, 3, 7, 1);
    set_q(1, 1, 0, 2, 0, 0);
    cfg_max_outst = 2;
    expect_grant(0, 3); expect_grant(0, 3);
    run_case(10);

    // R2: count limited by free buffer space.
    begin_case("R2 free space");
    set_q(0, 1, 3, 20, 0, 0);
    cfg_max_burst = 15;
    expect_grant(0, 13);
    run_case(8);

    // R6: disabled, empty host ring and full buffer are all skipped.
    begin_case("R6 ineligible");
    set_q(0, 0, 0, 20, 7, 0);
    set_q(1, 1, 0, 0, 6, 0);
    set_q(2, 1, 16, 20, 5, 0);
    set_q(3, 1, 0, 1, 0, 0);
    cfg_max_outst = 2;
    expect_grant(3, 1); expect_grant(3, 1);
    run_case(10);

    // R9: promotion keeps the current queue.
    begin_case("R9 promotion");
    set_q(0, 1, 0, 20, 3, 0);
    set_q(1, 1, 0, 20, 3, 0);
    cfg_promo_en = 1; cfg_promo_thr = 2; cfg_max_outst = 3;
    expect_grant(0, 8); expect_grant(0, 8); expect_grant(0, 8);
    run_case(10);

    // R9: level not below the promotion threshold, so rotation resumes.
    begin_case("R9 no promotion");
    set_q(0, 1, 0, 20, 3, 0);
    set_q(1, 1, 0, 20, 3, 0);
    cfg_promo_en = 1; cfg_promo_thr = 0; cfg_max_outst = 3;
    expect_grant(0, 8); expect_grant(1, 8); expect_grant(0, 8);
    run_case(10);

    // R10: forced promotion.
    begin_case("R10 forced promotion");
    set_q(0, 1, 0, 20, 3, 0);
    set_q(1, 1, 0, 20, 3, 0);
    cfg_promo_force = 1; cfg_max_outst = 3;
    expect_grant(0, 8); expect_grant(0, 8); expect_grant(0, 8);
    run_case(10);

    // R11: credit limit and return.
    begin_case("R11 credit");
    set_q(0, 1, 0, 20, 0, 0);
    cfg_max_outst = 2;
    expect_grant(0, 8); expect_grant(0, 8);
    run_case(10);
    expect_grant(0, 8);
    rd_done = 1;
    @(negedge clk);
    rd_done = 0;
    repeat (6) @(negedge clk);
    #1;
    check(exp_q.size() == 0, "R11", "grant after credit return", exp_q.size(), 0);

    // R11: zero limit blocks every grant.
    begin_case("R11 zero limit");
    set_q(0, 1, 0, 20, 0, 0);
    cfg_max_outst = 0;
    run_case(8);

    // R12: almost-full flag at and below the threshold.
    begin_case("R12 almost full");
    set_q(0, 0, 12, 0, 0, 0);
    set_q(1, 0, 11, 0, 0, 0);
    #1;
    check(afull[0] == 1'b1, "R12", "afull at threshold", int'(afull[0]), 1);
    check(afull[1] == 1'b0, "R12", "afull below threshold", int'(afull[1]), 0);

    @(negedge clk);
    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule